// File: doc/BRIEF.md
# Multithreaded Direct-Mapped Branch Target Buffer

This block predicts taken-branch targets for a fetch unit that serves several hardware threads. Each cycle it can accept one lookup, made of a fetch PC and a thread number, and one training write, made of a branch PC, its resolved target and a thread number. One cycle after a lookup it reports whether a matching entry exists, together with the stored target.

Storage is a single direct-mapped table. The set is picked from the PC bits just above the instruction alignment. The thread number is folded into the upper index bits, so different threads that run the same code land in different sets. The PC bits above the index form the tag. Each entry also keeps the thread number that wrote it. Entries are never merged or aged. A training write simply replaces whatever the indexed set held. A synchronous reset or a flush pulse empties the whole table in one cycle.

Entry count, tag width, alignment shift, thread count, PC width and target width are all parameters. The entry count and the thread count must be powers of two, with no more threads than entries. Any other setting is rejected at elaboration.

Top module: `btb_mt`

## Requirements
- R1: The set index is `((pc >> ALIGN_SHIFT) ^ (tid << (log2(ENTRIES) - log2(THREADS))))` truncated to log2(ENTRIES) bits. With the defaults (ENTRIES=64, THREADS=4, ALIGN_SHIFT=2) this is pc[7:2] XOR {tid, 4'b0000}. Two requests with the same index share one entry.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `lk_valid` high, and `rsp_hit`/`rsp_target` belong to that lookup. `rsp_hit` is never high while `rsp_valid` is low.
- R3: A training write with `up_valid` high always replaces the indexed entry. It marks the entry valid and stores the tag, target and thread number, without checking what the entry held before.
- R4: A lookup hits only if three conditions hold: the indexed entry is valid, its stored tag equals the lookup tag, and its stored thread number equals `lk_tid`.
- R5: On a miss, `rsp_target` is all zeros. On a hit it is the stored target.
- R6: The tag is `pc >> (ALIGN_SHIFT + log2(ENTRIES))` truncated to TAG_W bits. With the defaults this is pc[15:8].
- R7: While `rst` is high, every entry becomes invalid. A lookup made in a reset cycle gives no response, so `rsp_valid` is 0 in the following cycle.
- R8: If a lookup and a training write target the same set in the same cycle, the lookup reports the contents from before the write.
- R9: A `flush` pulse invalidates every entry in one cycle. A training write in the flush cycle is discarded. A lookup in the flush cycle reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries this cycle |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup PC |
| lk_tid | input | TID_W | Lookup thread number |
| up_valid | input | 1 | Training write request |
| up_pc | input | PC_W | Branch PC to train |
| up_tid | input | TID_W | Thread number of the trained branch |
| up_target | input | TGT_W | Target to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response found a matching entry |
| rsp_target | output | TGT_W | Predicted target, zero on a miss |

## Verification
Every lookup result is due exactly one clock after the edge that samples the request. A training write or flush becomes visible to a lookup issued one cycle later.

The bench's model uses the same timing. At each rising edge it computes the expected response from the table state before that edge's write or flush, and only then applies the write or flush to its own table. The outputs are compared at the following falling edge.

Directed checks also wait one full cycle after driving a lookup before reading the outputs. This covers same-cycle write/lookup collisions, alias evictions between threads, and flush and reset cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

  function automatic int tid_width(input int threads);
    return (threads > 1) ? $clog2(threads) : 1;
  endfunction

endpackage

// File: rtl/btb_hash.sv
module btb_hash #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 64,
  parameter int TAG_W       = 8,
  parameter int ALIGN_SHIFT = 2,
  parameter int THREADS     = 4,
  parameter int TID_W       = btb_pkg::tid_width(THREADS),
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [TID_W-1:0] tid,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  localparam int THR_LG    = $clog2(THREADS);
  localparam int TID_SHIFT = IDX_W - THR_LG;

  logic [IDX_W-1:0] pc_idx;
  logic unused_hash_bits;

  assign pc_idx = pc[ALIGN_SHIFT +: IDX_W];
  assign tag    = pc[ALIGN_SHIFT + IDX_W +: TAG_W];
  assign unused_hash_bits = ^{pc, tid};

  if (THREADS > 1) begin : g_mt
    logic [IDX_W-1:0] tid_term;
    assign tid_term = IDX_W'(tid) << TID_SHIFT;
    assign idx      = pc_idx ^ tid_term;
  end else begin : g_st
    assign idx = pc_idx;
  end

endmodule

// File: rtl/btb_valid_bits.sv
module btb_valid_bits #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic             rd_q
);
  logic [ENTRIES-1:0] vbits;

  always_ff @(posedge clk) begin
    if (clr) begin
      vbits <= '0;
    end else if (we) begin
      vbits[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= re & vbits[ridx];
    end
  end

endmodule

// File: rtl/btb_entry_ram.sv
module btb_entry_ram #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 42,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/btb_mt.sv
module btb_mt #(
  parameter int PC_W        = 32,
  parameter int TGT_W       = 32,
  parameter int ENTRIES     = 64,
  parameter int TAG_W       = 8,
  parameter int ALIGN_SHIFT = 2,
  parameter int THREADS     = 4,
  parameter int TID_W       = btb_pkg::tid_width(THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [TID_W-1:0] lk_tid,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [TID_W-1:0] up_tid,
  input  logic [TGT_W-1:0] up_target,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TGT_W-1:0] rsp_target
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int DATA_W = TAG_W + TID_W + TGT_W;

  if (!btb_pkg::is_pow2(ENTRIES)) begin : g_bad_entries
    $error("btb_mt: ENTRIES must be a power of two");
  end
  if (!btb_pkg::is_pow2(THREADS) || THREADS > ENTRIES) begin : g_bad_threads
    $error("btb_mt: THREADS must be a power of two no larger than ENTRIES");
  end

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  btb_hash #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W),
    .ALIGN_SHIFT(ALIGN_SHIFT), .THREADS(THREADS), .TID_W(TID_W)
  ) u_lk_hash (
    .pc(lk_pc), .tid(lk_tid), .idx(lk_idx), .tag(lk_tag)
  );

  btb_hash #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W),
    .ALIGN_SHIFT(ALIGN_SHIFT), .THREADS(THREADS), .TID_W(TID_W)
  ) u_up_hash (
    .pc(up_pc), .tid(up_tid), .idx(up_idx), .tag(up_tag)
  );

  logic clr_all;
  logic wr_en;
  assign clr_all = rst | flush;
  assign wr_en   = up_valid & ~clr_all;

  logic rd_valid;
  btb_valid_bits #(.ENTRIES(ENTRIES)) u_valid (
    .clk(clk), .clr(clr_all),
    .we(wr_en), .widx(up_idx),
    .re(lk_valid), .ridx(lk_idx),
    .rd_q(rd_valid)
  );

  logic [DATA_W-1:0] wr_word, rd_word;
  assign wr_word = {up_tag, up_tid, up_target};

  btb_entry_ram #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_ram (
    .clk(clk),
    .we(wr_en), .waddr(up_idx), .wdata(wr_word),
    .re(lk_valid), .raddr(lk_idx),
    .rdata(rd_word)
  );

  logic             req_q;
  logic [TAG_W-1:0] req_tag_q;
  logic [TID_W-1:0] req_tid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      req_tag_q <= '0;
      req_tid_q <= '0;
    end else begin
      req_q <= lk_valid;
      if (lk_valid) begin
        req_tag_q <= lk_tag;
        req_tid_q <= lk_tid;
      end
    end
  end

  logic [TAG_W-1:0] ent_tag;
  logic [TID_W-1:0] ent_tid;
  logic [TGT_W-1:0] ent_tgt;
  logic             match;

  assign {ent_tag, ent_tid, ent_tgt} = rd_word;
  assign match = req_q & rd_valid & (ent_tag == req_tag_q) & (ent_tid == req_tid_q);

  assign rsp_valid  = req_q;
  assign rsp_hit    = match;
  assign rsp_target = match ? ent_tgt : '0;

endmodule

// File: rtl/btb_mt_sva.sv
module btb_mt_sva #(
  parameter int PC_W  = 32,
  parameter int TGT_W = 32,
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lk_valid,
  input logic [PC_W-1:0]  lk_pc,
  input logic [TID_W-1:0] lk_tid,
  input logic             up_valid,
  input logic [PC_W-1:0]  up_pc,
  input logic [TID_W-1:0] up_tid,
  input logic [TGT_W-1:0] up_target,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [TGT_W-1:0] rsp_target
);

  p_reset_idle_r7: assert property (@(posedge clk) rst |=> !rsp_valid && !rsp_hit);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_hit_has_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> rsp_target == '0);

  p_write_read_r3: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !flush) ##1
    (lk_valid && !up_valid && !flush && lk_pc == $past(up_pc) && lk_tid == $past(up_tid))
    |=> rsp_hit && rsp_target == $past(up_target, 2));

  p_flush_lookup_miss_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !rsp_hit);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush ##1 (lk_valid && !flush) |=> !rsp_hit);

endmodule

bind btb_mt btb_mt_sva #(.PC_W(PC_W), .TGT_W(TGT_W), .TID_W(TID_W)) u_sva (.*);

// File: tb/tb_btb_mt.sv
`timescale 1ns/1ps
module tb_btb_mt;
  localparam int ENT = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [1:0]  lk_tid = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [1:0]  up_tid = '0;
  logic [31:0] up_target = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_target;

  always #10 clk = ~clk;

  btb_mt dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_tid(lk_tid),
    .up_valid(up_valid), .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R7";

  // Reference model from the requirements (R1 index, R6 tag).
  function automatic int m_idx(input logic [31:0] pc, input logic [1:0] tid);
    return ((int'(pc >> 2)) ^ (int'(tid) << 4)) & (ENT - 1);
  endfunction
  function automatic int m_tagof(input logic [31:0] pc);
    return int'(pc >> 8) & 255;
  endfunction

  bit          m_v   [ENT];
  int          m_tag [ENT];
  int          m_tid [ENT];
  logic [31:0] m_tgt [ENT];
  bit          e_v, e_h, armed = 0;
  logic [31:0] e_t;
  string       e_req;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENT; i++) m_v[i] = 0;
      e_v = 0; e_h = 0; e_t = '0;
    end else begin
      e_v = lk_valid; e_h = 0; e_t = '0;
      if (lk_valid && !flush) begin
        int i;
        i = m_idx(lk_pc, lk_tid);
        if (m_v[i] && m_tag[i] == m_tagof(lk_pc) && m_tid[i] == int'(lk_tid)) begin
          e_h = 1; e_t = m_tgt[i];
        end
      end
      if (flush) begin
        for (int k = 0; k < ENT; k++) m_v[k] = 0;
      end else if (up_valid) begin
        int j;
        j = m_idx(up_pc, up_tid);
        m_v[j] = 1; m_tag[j] = m_tagof(up_pc); m_tid[j] = int'(up_tid); m_tgt[j] = up_target;
      end
    end
    e_req = cur_req;
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      n_tests++;
      if (rsp_valid !== e_v || rsp_hit !== e_h || rsp_target !== e_t) begin
        n_fail++;
        $display("FAIL %s model: v/h/t got %0b/%0b/%h expected %0b/%0b/%h",
                 e_req, rsp_valid, rsp_hit, rsp_target, e_v, e_h, e_t);
      end
    end
  end

  task automatic step(input logic lv, input logic [31:0] lp, input logic [1:0] lt,
                      input logic uv, input logic [31:0] upc, input logic [1:0] ut,
                      input logic [31:0] utg, input logic fl, input string req);
    cur_req = req;
    lk_valid = lv; lk_pc = lp; lk_tid = lt;
    up_valid = uv; up_pc = upc; up_tid = ut; up_target = utg;
    flush = fl;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eh, input logic [31:0] et);
    n_tests++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_target !== et) begin
      n_fail++;
      $display("FAIL %s direct: v/h/t got %0b/%0b/%h expected 1/%0b/%h",
               req, rsp_valid, rsp_hit, rsp_target, eh, et);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] PA = 32'h0000_1234;
  localparam logic [31:0] PB = PA ^ 32'h40;   // same set with tid 1, same tag
  localparam logic [31:0] PC = PA + 32'h100;  // same set, other tag
  localparam logic [31:0] PD = 32'h0000_2050;

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R7: reset state, lookups during reset give nothing
    step(1, PA, 0, 0, 0, 0, 0, 0, "R7");
    rst = 1'b0;
    // R2: idle cycle gives no response
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    n_tests++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      n_fail++; $display("FAIL R2 idle: v/h got %0b/%0b expected 0/0", rsp_valid, rsp_hit);
    end
    // R3: write then read back
    step(0, 0, 0, 1, PA, 0, 32'hAAAA_0000, 0, "R3");
    step(1, PA, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3", 1, 32'hAAAA_0000);
    // R4: same set and tag but different thread number -> miss, target zero (R5)
    step(1, PB, 1, 0, 0, 0, 0, 0, "R4");
    chk("R4", 0, 0);
    // R6: different tag in same set -> miss
    step(1, PC, 0, 0, 0, 0, 0, 0, "R6");
    chk("R6", 0, 0);
    // R1: aliasing through the thread hash evicts entries
    step(0, 0, 0, 1, PC, 0, 32'hCCCC_0000, 0, "R1");
    step(1, PA, 0, 0, 0, 0, 0, 0, "R1");
    chk("R1", 0, 0);
    step(1, PC, 0, 1, PB, 1, 32'hBBBB_0000, 0, "R1");
    chk("R1", 1, 32'hCCCC_0000);
    step(1, PB, 1, 0, 0, 0, 0, 0, "R1");
    chk("R1", 1, 32'hBBBB_0000);
    step(1, PC, 0, 0, 0, 0, 0, 0, "R5");
    chk("R5", 0, 0);
    // R8: same-cycle write and lookup see old contents
    step(1, PB, 1, 1, PB, 1, 32'h1111_0000, 0, "R8");
    chk("R8", 1, 32'hBBBB_0000);
    step(1, PB, 1, 0, 0, 0, 0, 0, "R8");
    chk("R8", 1, 32'h1111_0000);
    // R9: flush, with a lookup and a write in the flush cycle
    step(1, PB, 1, 1, PD, 2, 32'hDDDD_0000, 1, "R9");
    chk("R9", 0, 0);
    step(1, PB, 1, 0, 0, 0, 0, 0, "R9");
    chk("R9", 0, 0);
    step(1, PD, 2, 0, 0, 0, 0, 0, "R9");
    chk("R9", 0, 0);
    // R7: reset mid-run clears entries
    step(0, 0, 0, 1, PD, 2, 32'hDDDD_0000, 0, "R7");
    rst = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    rst = 1'b0;
    step(1, PD, 2, 0, 0, 0, 0, 0, "R7");
    chk("R7", 0, 0);
    // R1/R4: mixed traffic against the model on a small PC space
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      a = (32'($urandom % 4) << 8) | (32'($urandom % 64) << 2);
      b = (32'($urandom % 4) << 8) | (32'($urandom % 64) << 2);
      rst = ($urandom % 700) == 0;
      step(1'($urandom % 2), a, 2'($urandom % 4),
           1'($urandom % 3 == 0), b, 2'($urandom % 4), $urandom,
           1'($urandom % 97 == 0), "R4");
    end
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    finish_run();
  end

endmodule